// File: doc/BRIEF.md
# Instruction Queue Control

This block keeps the control and status state of one hardware instruction ring that feeds a processing engine. Software programs the ring's base address, its capacity in blocks of forty instructions, and two independent enables: one that admits new instructions from producers and one that lets queued instructions go out to the engine. The block tracks the write (tail) and read (head) slot indices, the number of queued entries, and the number of instructions the engine has taken but not yet completed.

A producer raises `push_valid`. In the same cycle the block answers with `push_ok` or `push_err`. The engine side sees `eng_req` while execution is on and work is queued. A dispatch happens in a cycle where `eng_req` and `eng_rdy` are both high. The engine reports each finished instruction with an `eng_done` strobe.

Software reads the in-flight count to drain the ring cleanly. The order is: turn admission off, wait until the count is zero, then turn execution off. Bring-up sets execution on before admission. The first part of the memory region holds a group area of 16 bytes per block of forty. The instruction area starts after it, at the next 128-byte boundary, and that address is presented on `inst_base`.

Top module: `instq_ctl`

## Requirements
- R1: After reset, all four registers read zero, `eng_req` is low, and any push is refused with `push_err`.
- R2: The register at address 0 holds the base address with bits [6:0] forced to zero, so it is 128-byte aligned. `inst_base` equals that base plus the group-area span, which is 16 × units rounded up to a multiple of 128.
- R3: The size register (address 1, bits [7:0]) holds a unit count. The usable depth is (units − 1) × 40, or 0 when units is 0. A push is accepted only while the queued level is below this depth. `free_cnt` equals the usable depth minus the level.
- R4: While the admit bit is 0, a push is answered with `push_err` in the same cycle and the tail index does not change.
- R5: An accepted push raises `push_ok` in the same cycle and advances the tail by one on the next edge. The tail wraps to 0 after slot units × 40 − 1.
- R6: `eng_req` is high exactly when the execute bit is 1 and the level is non-zero. A dispatch advances the head by one with the same wrap rule and lowers the level. Without `eng_rdy` the head holds.
- R7: The in-flight count rises by one on a dispatch and falls by one on `eng_done`. When both occur in the same cycle it is unchanged. A completion at zero leaves it at zero.
- R8: A write to the size register is ignored while the admit bit is 1 or while entries are queued. The old value reads back.
- R9: An accepted size write resets the head and tail to 0.
- R10: Bit 0 of the control register (address 2) is the admit bit. Bit 0 of the progress register (address 3) is the execute bit. Bits [31:16] of the progress register show the in-flight count and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 base, 1 size, 2 control, 3 progress) |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Readback of the selected register (combinational) |
| push_valid | input | 1 | Producer offers one instruction |
| push_ok | output | 1 | Offer accepted this cycle |
| push_err | output | 1 | Offer refused this cycle |
| tail_idx | output | 14 | Next slot to be written |
| eng_req | output | 1 | An instruction is available for the engine |
| eng_rdy | input | 1 | Engine takes the offered instruction |
| head_idx | output | 14 | Slot offered to the engine |
| eng_done | input | 1 | Engine completion strobe |
| inst_base | output | 48 | Address of the instruction area |
| free_cnt | output | 14 | Usable slots still open |

## Verification
`push_ok`, `push_err`, `eng_req`, `cfg_rdata` and `inst_base` are combinational, so they are due in the cycle the stimulus is applied. The bench drives inputs on the falling edge and reads these outputs one nanosecond later, before the next rising edge. The tail, head, level, in-flight count and register contents are each one register deep, so they change on the first rising edge after the stimulus. The bench reads them after the following falling edge. Long runs of pushes and dispatches are counted out cycle by cycle, so the expected indices, including the wrap at units × 40, come from the bench's own arithmetic.

// File: rtl/instq_pkg.sv
package instq_pkg;

  typedef enum logic [1:0] {
    REG_BASE = 2'd0,
    REG_SIZE = 2'd1,
    REG_CTRL = 2'd2,
    REG_PROG = 2'd3
  } reg_sel_e;

  localparam int SLOTS_PER_UNIT = 40;
  localparam int GRP_BYTES_PER_UNIT = 16;
  localparam int ALIGN_SH = 7;
  localparam int FLIGHT_LSB = 16;

  // Full ring span in slots.
  function automatic int ring_cap(input int units);
    return units * SLOTS_PER_UNIT;
  endfunction

  // Slots software may fill: one block of forty is held back.
  function automatic int usable_slots(input int units);
    return (units == 0) ? 0 : (units - 1) * SLOTS_PER_UNIT;
  endfunction

  // Byte span of the group area, padded to the alignment boundary.
  function automatic int grp_area_span(input int units);
    int raw;
    raw = units * GRP_BYTES_PER_UNIT;
    return ((raw + (1 << ALIGN_SH) - 1) >> ALIGN_SH) << ALIGN_SH;
  endfunction

endpackage

// File: rtl/instq_regs.sv
module instq_regs
  import instq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 48,
  parameter int UNIT_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              ring_empty,
  input  logic [CNT_W-1:0]  inflight,
  output logic [ADDR_W-1:0] base_o,
  output logic [UNIT_W-1:0] units_o,
  output logic              enq_en_o,
  output logic              exec_en_o,
  output logic              size_load_o
);

  logic [ADDR_W-1:0] base_q;
  logic [UNIT_W-1:0] units_q;
  logic              enq_q, exec_q;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  // Resizing is allowed only on a closed, drained ring.
  assign size_load_o = cfg_we && (cfg_addr == REG_SIZE) && !enq_q && ring_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      units_q <= '0;
      enq_q   <= 1'b0;
      exec_q  <= 1'b0;
    end else if (cfg_we) begin
      case (reg_sel_e'(cfg_addr))
        REG_BASE: base_q <= {cfg_wdata[ADDR_W-1:ALIGN_SH], {ALIGN_SH{1'b0}}};
        REG_SIZE: if (size_load_o) units_q <= cfg_wdata[UNIT_W-1:0];
        REG_CTRL: enq_q <= cfg_wdata[0];
        REG_PROG: exec_q <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (reg_sel_e'(cfg_addr))
      REG_BASE: cfg_rdata[ADDR_W-1:0] = base_q;
      REG_SIZE: cfg_rdata[UNIT_W-1:0] = units_q;
      REG_CTRL: cfg_rdata[0] = enq_q;
      REG_PROG: begin
        cfg_rdata[0] = exec_q;
        cfg_rdata[FLIGHT_LSB +: CNT_W] = inflight;
      end
      default: ;
    endcase
  end

  assign base_o    = base_q;
  assign units_o   = units_q;
  assign enq_en_o  = enq_q;
  assign exec_en_o = exec_q;

  AST_SIZE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == REG_SIZE && enq_q) |=> $stable(units_q)); // R8
  AST_CTRL_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == REG_CTRL) |=> (enq_q == $past(cfg_wdata[0]))); // R10

endmodule

// File: rtl/instq_ring.sv
module instq_ring
  import instq_pkg::*;
#(
  parameter int UNIT_W = 8,
  parameter int IDX_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UNIT_W-1:0] units,
  input  logic              enq_en,
  input  logic              exec_en,
  input  logic              push_valid,
  input  logic              eng_rdy,
  input  logic              clear,
  output logic              push_ok,
  output logic              push_err,
  output logic              eng_req,
  output logic              dispatch,
  output logic [IDX_W-1:0]  tail,
  output logic [IDX_W-1:0]  head,
  output logic [IDX_W-1:0]  free_cnt,
  output logic              empty
);

  logic [IDX_W-1:0] level, cap, usable;
  logic             room;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] idx,
                                            input logic [IDX_W-1:0] span);
    logic [IDX_W-1:0] nxt;
    nxt = idx + 1'b1;
    return (nxt == span) ? '0 : nxt;
  endfunction

  always_comb begin
    cap    = IDX_W'(ring_cap(int'(units)));
    usable = IDX_W'(usable_slots(int'(units)));
  end

  assign room     = level < usable;
  assign push_ok  = push_valid && enq_en && room;
  assign push_err = push_valid && !(enq_en && room);
  assign eng_req  = exec_en && (level != '0);
  assign dispatch = eng_req && eng_rdy;
  assign free_cnt = usable - level;
  assign empty    = (level == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      level <= '0;
    end else if (clear) begin
      head  <= '0;
      tail  <= '0;
      level <= '0;
    end else begin
      if (push_ok)  tail <= bump(tail, cap);
      if (dispatch) head <= bump(head, cap);
      case ({push_ok, dispatch})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= usable); // R3
  AST_REJECT_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_err && !clear) |=> $stable(tail)); // R4
  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && !push_ok && !clear) |=> (level == $past(level) - IDX_W'(1))); // R6

endmodule

// File: rtl/instq_flight.sv
module instq_flight #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dispatch,
  input  logic             done,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({dispatch, done})
        2'b10:   if (cnt != TOP) cnt <= cnt + 1'b1;
        2'b01:   if (cnt != '0)  cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  AST_FLIGHT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && !done && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1)); // R7
  AST_FLIGHT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dispatch && cnt == '0) |=> (cnt == '0)); // R7
  AST_FLIGHT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && done) |=> $stable(cnt)); // R7

endmodule

// File: rtl/instq_ctl.sv
module instq_ctl
  import instq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 48,
  parameter int UNIT_W = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(((1 << UNIT_W) - 1) * SLOTS_PER_UNIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              push_valid,
  output logic              push_ok,
  output logic              push_err,
  output logic [IDX_W-1:0]  tail_idx,
  output logic              eng_req,
  input  logic              eng_rdy,
  output logic [IDX_W-1:0]  head_idx,
  input  logic              eng_done,
  output logic [ADDR_W-1:0] inst_base,
  output logic [IDX_W-1:0]  free_cnt
);

  logic [ADDR_W-1:0] base;
  logic [UNIT_W-1:0] units;
  logic              enq_en, exec_en, size_load;
  logic              ring_empty, dispatch;
  logic [CNT_W-1:0]  inflight;

  instq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNIT_W(UNIT_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .ring_empty (ring_empty),
    .inflight   (inflight),
    .base_o     (base),
    .units_o    (units),
    .enq_en_o   (enq_en),
    .exec_en_o  (exec_en),
    .size_load_o(size_load)
  );

  instq_ring #(
    .UNIT_W(UNIT_W), .IDX_W(IDX_W)
  ) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .units     (units),
    .enq_en    (enq_en),
    .exec_en   (exec_en),
    .push_valid(push_valid),
    .eng_rdy   (eng_rdy),
    .clear     (size_load),
    .push_ok   (push_ok),
    .push_err  (push_err),
    .eng_req   (eng_req),
    .dispatch  (dispatch),
    .tail      (tail_idx),
    .head      (head_idx),
    .free_cnt  (free_cnt),
    .empty     (ring_empty)
  );

  instq_flight #(
    .CNT_W(CNT_W)
  ) u_flight (
    .clk     (clk),
    .rst_n   (rst_n),
    .dispatch(dispatch),
    .done    (eng_done),
    .cnt     (inflight)
  );

  // The instruction area follows the padded group area.
  assign inst_base = base + ADDR_W'(grp_area_span(int'(units)));

  AST_SIZE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    size_load |=> (head_idx == '0 && tail_idx == '0)); // R9

endmodule

// File: tb/instq_ctl_test.sv
`timescale 1ns/1ps
module instq_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        push_valid = 1'b0;
  logic        push_ok, push_err, eng_req;
  logic        eng_rdy = 1'b0;
  logic        eng_done = 1'b0;
  logic [13:0] tail_idx, head_idx, free_cnt;
  logic [47:0] inst_base;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  instq_ctl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .push_valid(push_valid),
    .push_ok(push_ok), .push_err(push_err), .tail_idx(tail_idx),
    .eng_req(eng_req), .eng_rdy(eng_rdy), .head_idx(head_idx),
    .eng_done(eng_done), .inst_base(inst_base), .free_cnt(free_cnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [47:0] span(input int u);
    return 48'((((u * 16) + 127) / 128) * 128);
  endfunction

  task automatic push_n(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      push_valid = 1'b1;
      #1 chk(req, push_ok, 1);
      step();
    end
    push_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 register clear", d, 0);
    end
    chk("R1 no request", eng_req, 0);
    push_valid = 1'b1;
    #1 chk("R1 push refused", push_err, 1);
    step();
    push_valid = 1'b0;
    chk("R1 tail held", tail_idx, 0);
  endtask

  task automatic t_base();
    logic [63:0] d;
    wr(2'd0, 64'h0000_1234_5678_9AFF);
    rd(2'd0, d);
    chk("R2 base aligned", d, 64'h0000_1234_5678_9A80);
    wr(2'd1, 64'd9);
    #1 chk("R2 span units 9", inst_base, 48'h1234_5678_9A80 + span(9));
    wr(2'd1, 64'd5);
    #1 chk("R2 span units 5", inst_base, 48'h1234_5678_9A80 + 48'd128);
  endtask

  task automatic t_enq_off();
    wr(2'd1, 64'd2);
    #1 chk("R3 usable depth", free_cnt, 40);
    push_valid = 1'b1;
    #1 chk("R4 refused while closed", push_err, 1);
    step();
    push_valid = 1'b0;
    chk("R4 tail unchanged", tail_idx, 0);
  endtask

  task automatic t_fill();
    wr(2'd2, 64'd1);
    push_n(40, "R5 accepted push");
    chk("R5 tail advanced", tail_idx, 40);
    chk("R3 no room left", free_cnt, 0);
    push_valid = 1'b1;
    #1 chk("R3 full refused", push_err, 1);
    step();
    push_valid = 1'b0;
    chk("R3 tail held when full", tail_idx, 40);
  endtask

  task automatic t_size_lock();
    logic [63:0] d;
    wr(2'd1, 64'd3);
    rd(2'd1, d);
    chk("R8 size locked while open", d, 2);
  endtask

  task automatic t_dispatch();
    logic [63:0] d;
    chk("R6 no request while exec off", eng_req, 0);
    wr(2'd3, 64'h0000_0000_FFFF_0001);
    rd(2'd3, d);
    chk("R10 count ignores writes", d, 64'h1);
    eng_rdy = 1'b1;
    for (int i = 0; i < 40; i++) begin
      #1 chk("R6 request offered", eng_req, 1);
      step();
    end
    eng_rdy = 1'b0;
    chk("R6 head advanced", head_idx, 40);
    chk("R6 drained", free_cnt, 40);
    #1 chk("R6 request drops when empty", eng_req, 0);
    rd(2'd3, d);
    chk("R7 count after dispatches", d, 64'h28_0001);
  endtask

  task automatic t_done();
    logic [63:0] d;
    eng_done = 1'b1;
    repeat (41) step();
    eng_done = 1'b0;
    rd(2'd3, d);
    chk("R7 floor at zero", d, 64'h1);
  endtask

  task automatic t_wrap();
    logic [63:0] d;
    wr(2'd3, 64'd0);
    push_n(40, "R5 push across wrap");
    chk("R5 tail wrapped", tail_idx, 0);
    wr(2'd3, 64'd1);
    #1 chk("R6 request with exec on", eng_req, 1);
    step();
    chk("R6 head held without ready", head_idx, 40);
    eng_rdy = 1'b1;
    step();
    chk("R6 head one step", head_idx, 41);
    eng_done = 1'b1;
    step();
    eng_rdy = 1'b0; eng_done = 1'b0;
    chk("R6 head second step", head_idx, 42);
    rd(2'd3, d);
    chk("R7 dispatch with completion", d, 64'h1_0001);
  endtask

  task automatic t_resize();
    logic [63:0] d;
    wr(2'd2, 64'd0);
    wr(2'd1, 64'd4);
    rd(2'd1, d);
    chk("R8 size locked while queued", d, 2);
    eng_rdy = 1'b1;
    repeat (38) step();
    eng_rdy = 1'b0;
    chk("R6 head wrapped", head_idx, 0);
    wr(2'd2, 64'd1);
    push_n(3, "R5 refill");
    eng_rdy = 1'b1;
    repeat (3) step();
    eng_rdy = 1'b0;
    chk("R6 head after refill", head_idx, 3);
    wr(2'd2, 64'd0);
    wr(2'd1, 64'd4);
    rd(2'd1, d);
    chk("R8 size accepted when idle", d, 4);
    chk("R9 tail reset", tail_idx, 0);
    chk("R9 head reset", head_idx, 0);
    chk("R3 new usable depth", free_cnt, 120);
    chk("R2 span units 4", inst_base, 48'h1234_5678_9A80 + span(4));
    push_valid = 1'b1;
    #1 chk("R4 closed after resize", push_err, 1);
    step();
    push_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_base();
    t_enq_off();
    t_fill();
    t_size_lock();
    t_dispatch();
    t_done();
    t_wrap();
    t_resize();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule